// File: doc/BRIEF.md
# NAND ECC Offload Engine Control and Interrupt Registers

This block is the software-visible control face of a NAND error-correction offload engine. A host processor reaches it through a simple 32-bit register bus with a write strobe, a byte offset and a read-data port that follows the offset combinationally. The block holds the engine enable, the correction-level index, the transfer-type settings, the chunk geometry, the DMA addresses and the chunk count. It presents all of these as plain outputs to the datapath, which is outside this block.

A write to the DMA control register with the start bit set sends a single-cycle start pulse to the datapath, together with the stored direction and continuation flags. The datapath reports back through six event pulses. Each event latches into a sticky status register only when its bit in the status-enable mask is set. The single interrupt line is the OR of the latched bits that the separate signal-enable mask lets through. Software clears status bits by writing ones to them, so writing back the value it has just read acknowledges everything it saw.

Top module: `ecc_ctl_regs`

## Requirements
- R1: After reset the status word, both interrupt masks, the configuration word, the host configuration word, the addresses and the chunk count read 0. `irq`, `engine_en` and `xfer_start` are 0. Offset 0x20 reads DEF_CHUNK, offset 0x28 reads DEF_SPARE and offset 0x24 reads DEF_MAIN.
- R2: At offset 0x00, bit 0 is the engine enable and bits 6:3 are the correction-level index, driven on `engine_en` and `corr_level`. Every other bit reads 0.
- R3: The status word at 0x04 holds bit 0 transfer done, bit 1 main DMA done, bit 2 spare DMA done, bit 3 ECC error, bit 4 spare timeout and bit 5 main timeout, matching `evt_in[5:0]`. An event sets its bit only when the same bit of the status-enable mask at 0x08 is 1. Bits 31:6 of both words read 0.
- R4: Writing to 0x04 clears each status bit whose write-data bit is 1 and leaves the other bits as they are. Writing back a value just read clears all of the set bits.
- R5: When an enabled event and a write-one-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: `irq` is 1 exactly when some status bit and the same bit of the signal-enable mask at 0x0C are both 1. The signal-enable mask has no effect on which bits latch.
- R7: A write to 0x40 with bit 31 set raises `xfer_start` for exactly the one cycle that follows the write. Bit 1 (1 means read from NAND) drives `xfer_read`, bit 29 drives `cont_nand` and bit 30 drives `cont_sysmem`. Bit 31 always reads 0, and a write with bit 31 clear gives no pulse.
- R8: At 0x10, bit 0 selects incrementing bursts, bit 2 the interleaved layout, bit 4 memory-to-memory mode and bit 5 mapping mode. The other bits read 0.
- R9: The slave address at 0x14, the main address at 0x44, the spare address at 0x48 and the size words at 0x20, 0x24 and 0x28 read back all 32 bits as written. The chunk count at 0x30 keeps only its low CNT_W bits.
- R10: Offset 0xD0 reads VERSION in bits 31:16 and 0 below that, and writes to it have no effect.
- R11: Offsets that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| evt_in | input | 6 | Event pulses from the datapath |
| irq | output | 1 | Interrupt line |
| engine_en | output | 1 | Engine enable |
| corr_level | output | 4 | Correction-level index |
| burst_incr | output | 1 | Incrementing bursts |
| layout_ilv | output | 1 | Interleaved layout |
| mode_m2m | output | 1 | Memory-to-memory mode |
| mode_map | output | 1 | Mapping mode |
| slave_base | output | 32 | Slave address |
| chunk_bytes | output | 32 | Chunk size |
| main_bytes | output | 32 | Main data size |
| spare_fmt | output | 32 | Spare size word |
| chunk_total | output | CNT_W | Chunk count |
| main_base | output | 32 | Main DMA address |
| spare_base | output | 32 | Spare DMA address |
| xfer_start | output | 1 | One-cycle start pulse |
| xfer_read | output | 1 | Direction, 1 means read from NAND |
| cont_nand | output | 1 | Continue on NAND side |
| cont_sysmem | output | 1 | Continue in system memory |

## Verification
The bench builds the block with CNT_W = 6, so a 9-bit write to the chunk count visibly loses its upper bits. It sets VERSION = 16'h0303, a non-zero and asymmetric value that shows the version sits in the upper half-word. The size defaults are left at their normal values, and the reset check compares them. With the status-enable mask set to a sparse pattern, only some of six simultaneous events latch. Moving the signal-enable mask between a latched bit and an unlatched one then separates the two masking levels.

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs #(
  parameter int          CNT_W     = 8,
  parameter logic [15:0] VERSION   = 16'h0003,
  parameter logic [31:0] DEF_CHUNK = 32'd1024,
  parameter logic [31:0] DEF_MAIN  = 32'd1024,
  parameter logic [31:0] DEF_SPARE = 32'h2000_1A06
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [5:0]       evt_in,
  output logic             irq,
  output logic             engine_en,
  output logic [3:0]       corr_level,
  output logic             burst_incr,
  output logic             layout_ilv,
  output logic             mode_m2m,
  output logic             mode_map,
  output logic [31:0]      slave_base,
  output logic [31:0]      chunk_bytes,
  output logic [31:0]      main_bytes,
  output logic [31:0]      spare_fmt,
  output logic [CNT_W-1:0] chunk_total,
  output logic [31:0]      main_base,
  output logic [31:0]      spare_base,
  output logic             xfer_start,
  output logic             xfer_read,
  output logic             cont_nand,
  output logic             cont_sysmem
);
  localparam int          EVT_N  = 6;
  localparam logic [7:0]  A_CFG  = 8'h00, A_STS = 8'h04, A_SEN = 8'h08, A_GEN = 8'h0C;
  localparam logic [7:0]  A_HC   = 8'h10, A_SLV = 8'h14, A_CHK = 8'h20, A_MSZ = 8'h24;
  localparam logic [7:0]  A_SSZ  = 8'h28, A_CNT = 8'h30, A_DMA = 8'h40, A_MAD = 8'h44;
  localparam logic [7:0]  A_SAD  = 8'h48, A_VER = 8'hD0;

  logic [EVT_N-1:0] sts_q, sten_q, sgen_q, sts_clr;

  wire wr_cfg = bus_wr && bus_addr == A_CFG;
  wire wr_sts = bus_wr && bus_addr == A_STS;
  wire wr_dma = bus_wr && bus_addr == A_DMA;

  assign sts_clr = wr_sts ? bus_wdata[EVT_N-1:0] : '0;
  assign irq     = |(sts_q & sgen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | (evt_in & sten_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      engine_en  <= 1'b0;
      corr_level <= '0;
    end else if (wr_cfg) begin
      engine_en  <= bus_wdata[0];
      corr_level <= bus_wdata[6:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sten_q      <= '0;
      sgen_q      <= '0;
      burst_incr  <= 1'b0;
      layout_ilv  <= 1'b0;
      mode_m2m    <= 1'b0;
      mode_map    <= 1'b0;
      slave_base  <= '0;
      chunk_bytes <= DEF_CHUNK;
      main_bytes  <= DEF_MAIN;
      spare_fmt   <= DEF_SPARE;
      chunk_total <= '0;
      main_base   <= '0;
      spare_base  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_SEN: sten_q <= bus_wdata[EVT_N-1:0];
        A_GEN: sgen_q <= bus_wdata[EVT_N-1:0];
        A_HC: begin
          burst_incr <= bus_wdata[0];
          layout_ilv <= bus_wdata[2];
          mode_m2m   <= bus_wdata[4];
          mode_map   <= bus_wdata[5];
        end
        A_SLV: slave_base  <= bus_wdata;
        A_CHK: chunk_bytes <= bus_wdata;
        A_MSZ: main_bytes  <= bus_wdata;
        A_SSZ: spare_fmt   <= bus_wdata;
        A_CNT: chunk_total <= bus_wdata[CNT_W-1:0];
        A_MAD: main_base   <= bus_wdata;
        A_SAD: spare_base  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_start  <= 1'b0;
      xfer_read   <= 1'b0;
      cont_nand   <= 1'b0;
      cont_sysmem <= 1'b0;
    end else begin
      xfer_start <= wr_dma && bus_wdata[31];
      if (wr_dma) begin
        xfer_read   <= bus_wdata[1];
        cont_nand   <= bus_wdata[29];
        cont_sysmem <= bus_wdata[30];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CFG: bus_rdata = {25'd0, corr_level, 2'd0, engine_en};
      A_STS: bus_rdata[EVT_N-1:0] = sts_q;
      A_SEN: bus_rdata[EVT_N-1:0] = sten_q;
      A_GEN: bus_rdata[EVT_N-1:0] = sgen_q;
      A_HC:  bus_rdata = {26'd0, mode_map, mode_m2m, 1'b0, layout_ilv, 1'b0, burst_incr};
      A_SLV: bus_rdata = slave_base;
      A_CHK: bus_rdata = chunk_bytes;
      A_MSZ: bus_rdata = main_bytes;
      A_SSZ: bus_rdata = spare_fmt;
      A_CNT: bus_rdata[CNT_W-1:0] = chunk_total;
      A_DMA: bus_rdata = {1'b0, cont_sysmem, cont_nand, 27'd0, xfer_read, 1'b0};
      A_MAD: bus_rdata = main_base;
      A_SAD: bus_rdata = spare_base;
      A_VER: bus_rdata = {VERSION, 16'd0};
      default: bus_rdata = '0;
    endcase
  end

  p_latch_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q)) & ~$past(evt_in & sten_q)) == '0)
    else $error("status bit rose without an enabled event");

  p_clear_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(sts_q) & ~sts_q) &
     ~($past(bus_wr && bus_addr == A_STS) ? $past(bus_wdata[EVT_N-1:0]) : '0)) == '0)
    else $error("status bit dropped without a clear write");

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt_in & sten_q) & ~sts_q) == '0)
    else $error("enabled event did not leave its bit set");

  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start)
    else $error("start pulse longer than one cycle");

  p_start_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(bus_wr && bus_addr == A_DMA && bus_wdata[31]))
    else $error("start pulse without a start write");
endmodule

// File: tb/tb_ecc_ctl_regs.sv
module tb_ecc_ctl_regs;
  localparam int          CNT_W = 6;
  localparam logic [15:0] VER   = 16'h0303;

  logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [5:0]  evt_in = '0;
  logic        irq, engine_en, burst_incr, layout_ilv, mode_m2m, mode_map;
  logic [3:0]  corr_level;
  logic [31:0] slave_base, chunk_bytes, main_bytes, spare_fmt, main_base, spare_base;
  logic [CNT_W-1:0] chunk_total;
  logic        xfer_start, xfer_read, cont_nand, cont_sysmem;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ecc_ctl_regs #(.CNT_W(CNT_W), .VERSION(VER)) dut (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .evt_in, .irq,
    .engine_en, .corr_level, .burst_incr, .layout_ilv, .mode_m2m, .mode_map,
    .slave_base, .chunk_bytes, .main_bytes, .spare_fmt, .chunk_total,
    .main_base, .spare_base, .xfer_start, .xfer_read, .cont_nand, .cont_sysmem);

  // {offset, write data, expected read-back}
  localparam logic [71:0] VEC [0:10] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0000_0079},  // R2
    {8'h10, 32'hFFFF_FFFF, 32'h0000_0035},  // R8
    {8'h14, 32'hA5A5_1234, 32'hA5A5_1234},  // R9
    {8'h30, 32'h0000_01FF, 32'h0000_003F},  // R9
    {8'h44, 32'hDEAD_BEE0, 32'hDEAD_BEE0},  // R9
    {8'h48, 32'h0000_0FFC, 32'h0000_0FFC},  // R9
    {8'h40, 32'h6000_0002, 32'h6000_0002},  // R7
    {8'hD0, 32'hFFFF_FFFF, 32'h0303_0000},  // R10
    {8'h18, 32'hFFFF_FFFF, 32'h0000_0000},  // R11
    {8'h20, 32'h0000_0800, 32'h0000_0800},  // R9
    {8'h08, 32'hFFFF_FFFF, 32'h0000_003F}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic pulse(input logic [5:0] e);
    evt_in = e; @(posedge clk); @(negedge clk); evt_in = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, r); chk("R1 cfg", r, 0);
    rd(8'h04, r); chk("R1 sts", r, 0);
    rd(8'h08, r); chk("R1 sten", r, 0);
    rd(8'h0C, r); chk("R1 sgen", r, 0);
    rd(8'h20, r); chk("R1 chunk", r, 32'd1024);
    rd(8'h24, r); chk("R1 main", r, 32'd1024);
    rd(8'h28, r); chk("R1 spare", r, 32'h2000_1A06);
    rd(8'h30, r); chk("R1 cnt", r, 0);
    chk("R1 irq/en/start", {irq, engine_en, xfer_start}, 0);

    for (int i = 0; i < 11; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      chk("R7 no start", {31'd0, xfer_start}, 0);
      rd(VEC[i][71:64], r);
      chk("vector read-back", r, VEC[i][31:0]);
    end
    chk("R2 ports", {27'd0, engine_en, corr_level}, 32'h1F);
    chk("R8 ports", {28'd0, mode_map, mode_m2m, layout_ilv, burst_incr}, 32'hF);
    chk("R9 cnt port", {26'd0, chunk_total}, 32'h3F);
    chk("R7 flags", {29'd0, cont_sysmem, cont_nand, xfer_read}, 32'h7);

    wr(8'h00, 32'h0000_0010);
    chk("R2 level", {27'd0, engine_en, corr_level}, 32'h02);

    // R3 gated latch
    wr(8'h08, 32'h0000_0005);
    pulse(6'h3F);
    rd(8'h04, r); chk("R3 gated latch", r, 32'h05);
    // R6 mask levels
    chk("R6 irq masked", {31'd0, irq}, 0);
    wr(8'h0C, 32'h0000_0004);
    chk("R6 irq on", {31'd0, irq}, 1);
    wr(8'h0C, 32'h0000_0002);
    chk("R6 unlatched bit", {31'd0, irq}, 0);
    wr(8'h0C, 32'h0000_0005);
    // R4 write-one-clear
    wr(8'h04, 32'h0000_0001);
    rd(8'h04, r); chk("R4 partial clear", r, 32'h04);
    wr(8'h04, r);
    rd(8'h04, r); chk("R4 write-back clear", r, 0);
    chk("R6 irq after clear", {31'd0, irq}, 0);

    // R5 set beats clear
    wr(8'h08, 32'h0000_003F);
    pulse(6'h08);
    rd(8'h04, r); chk("R5 setup", r, 32'h08);
    evt_in = 6'h08; wr(8'h04, 32'h0000_0008); evt_in = '0;
    rd(8'h04, r); chk("R5 set wins", r, 32'h08);
    evt_in = 6'h02; wr(8'h04, 32'h0000_0008); evt_in = '0;
    rd(8'h04, r); chk("R5 other bit", r, 32'h02);

    // R7 start pulse
    wr(8'h40, 32'h8000_0002);
    chk("R7 pulse", {30'd0, xfer_start, xfer_read}, 32'h3);
    rd(8'h40, r); chk("R7 readback", r, 32'h2);
    @(negedge clk);
    chk("R7 pulse ends", {31'd0, xfer_start}, 0);
    wr(8'h40, 32'hA000_0000);
    chk("R7 write start", {28'd0, xfer_start, cont_sysmem, cont_nand, xfer_read}, 32'hA);
    @(negedge clk);
    chk("R7 one cycle", {31'd0, xfer_start}, 0);

    finish_run();
  end
endmodule